// File: doc/BRIEF.md
# TDM Timeslot Data Strobe Generator

This block produces a programmable strobe for a serial time-division-multiplexed frame. The frame has 32 timeslots of eight bits each, sent MSB first and counted from a frame sync pulse. A single 8-bit control register names a base slot. It also switches on any mix of three windows, each placed relative to that base slot. The first window covers the whole base slot. The second covers the whole slot after it. The third is a two-bit window that covers the first two bits of the slot three places after the base. A simple serial device can use the strobe to pick one programmable channel out of the frame.

Everything runs on the bit clock. The frame sync rising edge restarts the bit position counter. A register write goes into a shadow copy and is moved into the active copy only at the next frame sync, so no frame ever carries a partly updated strobe. A pin selects the output form. In level form the output is the strobe itself, high for whole bit periods. In gated form the output is a pulse during the low half of each enabled bit period, which gives one clean clock pulse per strobed bit.

Top module: `tdm_strobe_gen`

## Requirements
- R1: After reset the register reads 0x00 and the strobe output is low.
- R2: A write loads the register at the clock edge, and the value reads back from the next cycle on. Bit 7 enables the base-slot window, bit 6 enables the following-slot window, bit 5 enables the two-bit window, and bits 4:0 hold the base slot number.
- R3: The first rising clock edge at which frame sync is seen high starts frame position 0. Position p is slot p/8, bit 7-(p mod 8). The position advances by one at every later edge and wraps from 255 to 0. A sync held high for several cycles restarts the frame only once.
- R4: With bit 7 set, the strobe is high for all 8 positions of the base slot.
- R5: With bit 6 set, the strobe is high for all 8 positions of slot (base+1) mod 32.
- R6: With bit 5 set, the strobe is high only for the first two positions (bits 7 and 6) of slot (base+3) mod 32.
- R7: The output is the union of the enabled windows. With all three enables clear, the strobe never goes high.
- R8: A written value takes effect only at the next frame sync edge. A write made at the same edge as a sync waits for the sync after that.
- R9: In level mode (cfgGated=0) the output equals the strobe for the whole bit period. In gated mode (cfgGated=1) the output is low while the bit clock is high and equals the strobe while it is low.
- R10: Slot numbers wrap modulo 32. Base slots 29 to 31 place the following windows at the start of the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fsync | input | 1 | Frame sync; its rising edge marks position 0 |
| wrEn | input | 1 | Register write enable |
| wrData | input | 8 | Register write data |
| cfgGated | input | 1 | Output form: 0 level, 1 gated clock |
| rdData | output | 8 | Register read data (shadow copy) |
| strobeOut | output | 1 | Strobe level or gated bit-clock pulses |

## Verification
The bench goes after slot wrap at bases 29 to 31. A design that skips the modulo would drop the following windows or place them in a slot that does not exist. It also checks that the two-bit window ends after bit 6; a wrong comparison would strobe the whole slot. It tests writes made mid-frame and at the same edge as a sync. A design without a shadow copy would tear the current frame, and one that reads the newly written value at that edge would act a frame early. Long sync pulses and early syncs are also driven: a level-triggered restart would hold the counter at zero. In gated mode the output is sampled in both clock phases, so a design that gates on the wrong phase shows pulses while the clock is high.

// File: rtl/tdm_strobe_pkg.sv
package tdm_strobe_pkg;

  localparam int NUM_SLOTS = 32;
  localparam int SLOT_BITS = 8;
  localparam int NEXT_OFF  = 1;
  localparam int DCH_OFF   = 3;
  localparam int DCH_BITS  = 2;
  localparam int NUM_WIN   = 3;

  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int BIT_W  = $clog2(SLOT_BITS);
  localparam int POS_W  = SLOT_W + BIT_W;
  localparam int REG_W  = NUM_WIN + SLOT_W;

  typedef struct packed {
    logic              enBase;
    logic              enNext;
    logic              enDch;
    logic [SLOT_W-1:0] baseSlot;
  } slotCfg_t;

  typedef struct packed {
    logic     frameStart;
    slotCfg_t cfgUse;
  } ctrlStrobe_t;

  function automatic int winOffset(input int w);
    case (w)
      0:       return 0;
      1:       return NEXT_OFF;
      default: return DCH_OFF;
    endcase
  endfunction

  function automatic int winLen(input int w);
    return (w == 2) ? DCH_BITS : SLOT_BITS;
  endfunction

  function automatic logic winEnable(input slotCfg_t c, input int w);
    case (w)
      0:       return c.enBase;
      1:       return c.enNext;
      default: return c.enDch;
    endcase
  endfunction

endpackage

// File: rtl/tdm_strobe_ctrl.sv
module tdm_strobe_ctrl
  import tdm_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fsync,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output ctrlStrobe_t      ctrlOut
);

  slotCfg_t shadowCfg;
  slotCfg_t activeCfg;
  logic     fsyncQ;
  logic     syncEdge;

  assign syncEdge = fsync & ~fsyncQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsyncQ <= 1'b0;
    end else begin
      fsyncQ <= fsync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadowCfg <= '0;
    end else if (wrEn) begin
      shadowCfg <= slotCfg_t'(wrData);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeCfg <= '0;
    end else if (syncEdge) begin
      activeCfg <= shadowCfg;
    end
  end

  always_comb begin
    ctrlOut.frameStart = syncEdge;
    ctrlOut.cfgUse     = syncEdge ? shadowCfg : activeCfg;
  end

  assign rdData = REG_W'(shadowCfg);

  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> rdData == $past(wrData));

  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlOut.frameStart |=> $stable(activeCfg));

endmodule

// File: rtl/tdm_strobe_dp.sv
module tdm_strobe_dp
  import tdm_strobe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfgGated,
  input  ctrlStrobe_t ctrlIn,
  output logic        strobeOut
);

  logic [POS_W-1:0]  posQ;
  logic [POS_W-1:0]  posNext;
  logic [SLOT_W-1:0] slotNext;
  logic [BIT_W-1:0]  bitNext;
  logic [NUM_WIN-1:0] winHit;
  logic              strobeQ;

  always_comb begin
    posNext  = ctrlIn.frameStart ? '0 : posQ + 1'b1;
    slotNext = posNext[POS_W-1:BIT_W];
    bitNext  = posNext[BIT_W-1:0];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam int OFF = winOffset(w);
    localparam int LEN = winLen(w);
    logic              winEn;
    logic [SLOT_W-1:0] target;
    logic              inLen;
    assign winEn     = winEnable(ctrlIn.cfgUse, w);
    assign target    = ctrlIn.cfgUse.baseSlot + SLOT_W'(OFF);
    assign inLen     = {1'b0, bitNext} < (BIT_W+1)'(LEN);
    assign winHit[w] = winEn && (slotNext == target) && inLen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      posQ    <= '0;
      strobeQ <= 1'b0;
    end else begin
      posQ    <= posNext;
      strobeQ <= |winHit;
    end
  end

  // Strobe changes on the rising edge while the low phase is not yet open.
  assign strobeOut = cfgGated ? (strobeQ & ~clk) : strobeQ;

  assert_pos_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrlIn.frameStart |=> posQ == '0);

  assert_pos_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrlIn.frameStart |=> posQ == POS_W'($past(posQ) + 1'b1));

  assert_quiet_when_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrlIn.cfgUse.enBase | ctrlIn.cfgUse.enNext | ctrlIn.cfgUse.enDch) |=> !strobeQ);

  assert_dch_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (strobeQ && (posQ[BIT_W-1:0] >= BIT_W'(DCH_BITS)))
      |-> ($past(ctrlIn.cfgUse.enBase) || $past(ctrlIn.cfgUse.enNext)));

endmodule

// File: rtl/tdm_strobe_gen.sv
module tdm_strobe_gen
  import tdm_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsync,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       cfgGated,
  output logic [7:0] rdData,
  output logic       strobeOut
);

  ctrlStrobe_t ctrlBus;

  tdm_strobe_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .fsync   (fsync),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .ctrlOut (ctrlBus)
  );

  tdm_strobe_dp u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfgGated  (cfgGated),
    .ctrlIn    (ctrlBus),
    .strobeOut (strobeOut)
  );

endmodule

// File: tb/tdm_strobe_gen_bench.sv
module tdm_strobe_gen_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       cfgGated = 1'b0;
  logic [7:0] rdData;
  logic       strobeOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model
  int       mPos = 0;
  logic [7:0] mShadow = 8'h00;
  logic [7:0] mActive = 8'h00;
  bit       mPrevFs = 0;

  always #4 clk = ~clk;

  tdm_strobe_gen u_tdm_strobe_gen (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .wrEn(wrEn), .wrData(wrData),
    .cfgGated(cfgGated), .rdData(rdData), .strobeOut(strobeOut)
  );

  function automatic bit expHit(input int p, input logic [7:0] c);
    int slot = p / 8;
    int b = p % 8;
    int t = int'(c[4:0]);
    return (c[7] && slot == t) || (c[6] && slot == (t + 1) % 32) ||
           (c[5] && slot == (t + 3) % 32 && b < 2);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (pos=%0d cfg=%h)", tag, act, exp, mPos, mActive);
    end
  endtask

  // Called in the low clock phase; drives, steps one edge, checks both phases.
  task automatic step(input bit fs, input bit we, input logic [7:0] wd, input string tag);
    bit e;
    fsync = fs; wrEn = we; wrData = wd;
    @(posedge clk);
    if (fs && !mPrevFs) begin mPos = 0; mActive = mShadow; end
    else mPos = (mPos + 1) % 256;
    mPrevFs = fs;
    if (we) mShadow = wd;
    e = expHit(mPos, mActive);
    #1;
    chk("R2", rdData, mShadow);
    if (cfgGated) chk("R9", {7'd0, strobeOut}, 8'd0);
    else chk(tag, {7'd0, strobeOut}, {7'd0, e});
    #4;
    chk(cfgGated ? "R9" : tag, {7'd0, strobeOut}, {7'd0, e});
  endtask

  task automatic frame(input int len, input string tag, input int wrAt, input logic [7:0] wv);
    for (int i = 0; i < len; i++)
      step(i == 0, i == wrAt, wv, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #5;
    rst_n = 1'b1;
    chk("R1", rdData, 8'h00);
    chk("R1", {7'd0, strobeOut}, 8'd0);

    // R7: nothing enabled, free run then a frame
    frame(40, "R7", -1, 8'h00);
    frame(256, "R7", -1, 8'h00);
    // R8: write mid-frame, strobe must stay off this frame
    frame(256, "R8", 10, 8'h80);
    frame(256, "R4", -1, 8'h00);            // base slot 0
    frame(256, "R5", 5, 8'h45);             // next slot 6 (active next frame)
    frame(256, "R5", 7, 8'h3E);
    frame(256, "R6", -1, 8'h00);            // D window slot 1 after wrap, R10
    // R8: write on the sync edge waits one more frame
    frame(256, "R6", 0, 8'hFF);
    frame(256, "R8", -1, 8'h00);
    frame(256, "R10", -1, 8'h00);           // base 31, all windows, wrap
    // R3: sync held high for 3 cycles counts once
    for (int i = 0; i < 3; i++) step(1, 0, 8'h00, "R3");
    for (int i = 0; i < 253; i++) step(0, 0, 8'h00, "R3");
    // R9: gated mode
    cfgGated = 1'b1;
    frame(256, "R9", 100, 8'hBD);
    frame(256, "R9", -1, 8'h00);
    cfgGated = 1'b0;

    // random frames, random lengths and writes (R7 union)
    for (int f = 0; f < 30; f++) begin
      int len = ($urandom % 4 == 0) ? 120 + int'($urandom % 136) : 256;
      int wa  = int'($urandom % 256);
      cfgGated = ($urandom % 3 == 0);
      frame(len, "R7", wa, 8'($urandom));
    end
    cfgGated = 1'b0;
    frame(256, "R7", -1, 8'h00);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule